// File: doc/BRIEF.md
# PCI Target Delayed Read Controller

This block is the target side of a 32-bit PCI interface. It turns single-data-phase reads into delayed transactions. When a read hits the block's address window and nothing is pending, the block stores the command, the address and the byte enables. It ends the bus transaction with a retry and hands the stored request to the application as a one-cycle push. The application answers by writing the read data into a small internal FIFO.

The remote master must keep reissuing the same read. Each repeat that arrives while the FIFO is still empty is retried. So is any other access to the window while the request is pending. Once data is waiting, a repeat that matches the stored command, address and byte enables exactly is completed with a disconnect-with-data: target ready and stop are driven together and the oldest FIFO word is placed on the bus. After that transaction ends, the word is popped, the pending request is dropped, and the block can accept a new request.

Decode uses medium timing: the target signals go active on the second clock after the address clock. A mode input turns the delayed handling off completely, and the block then claims nothing.

Top module: `pci_dlyrd_tgt`

## Requirements
- R1: After a synchronous reset, tgt_devsel_l, tgt_trdy_l and tgt_stop_l are high, tgt_ad_oe is 0, req_push is 0, rd_full is 0 and no request is pending.
- R2: An address clock is a clock where bus_frame_l is low, bus_frame_l was high in the clock before, and the block is idle. For a claimed access, tgt_devsel_l and tgt_stop_l go low two clocks after the address clock. They stay low until bus_frame_l is sampled high while bus_irdy_l is low, and they are high from the next clock on. tgt_trdy_l follows the same rule when data is given.
- R3: An I/O read (command 4'b0010) or memory read (4'b0110) to the window, arriving with no request pending, is retried (stop low, trdy high). In the same clock that devsel goes low, req_push is high for exactly one clock. req_cmd and req_addr then carry the address-clock command and address, and req_be carries bus_cbe_l from the clock after the address clock.
- R4: While a request is pending, a claimed access is retried without data, without a push and without a pop. This covers I/O read/write (4'b0010/4'b0011) and memory read/write (4'b0110/4'b0111) in the window. It applies when any of command, full address or byte enables differs from the stored values, and also when they all match but the FIFO is empty.
- R5: A matching repeat while the FIFO holds data drives tgt_trdy_l and tgt_stop_l low together with tgt_devsel_l. In those clocks tgt_ad_oe is 1 and tgt_ad equals the oldest FIFO word.
- R6: When a completing transaction ends, exactly one FIFO word is removed and the pending request is cleared. The next read to the window is then captured as a new request.
- R7: An access whose address is outside the window, or whose command is not one of the four above, gets no devsel, no push and no change of state.
- R8: While bypass_dly is 1 at the address clock, the access is not claimed and causes no push.
- R9: Words written with rd_push leave the FIFO in the order they were written. rd_full is 1 while FIFO_DEPTH words are held, and a push while full is discarded.
- R10: A write to the window (4'b0011 or 4'b0111) with no request pending is retried and causes no push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_dly | input | 1 | 1 disables delayed read handling (nothing is claimed) |
| bus_frame_l | input | 1 | Cycle frame from the master, active low |
| bus_irdy_l | input | 1 | Initiator ready, active low |
| bus_ad | input | 32 | Multiplexed address/data from the bus |
| bus_cbe_l | input | 4 | Command in the address clock, byte enables afterwards |
| tgt_devsel_l | output | 1 | Device select, active low |
| tgt_trdy_l | output | 1 | Target ready, active low |
| tgt_stop_l | output | 1 | Stop request, active low |
| tgt_ad | output | 32 | Read data driven to the bus |
| tgt_ad_oe | output | 1 | Output enable for tgt_ad |
| req_push | output | 1 | One-clock push of a captured request |
| req_cmd | output | 4 | Captured command |
| req_addr | output | 32 | Captured address |
| req_be | output | 4 | Captured byte enables (active low) |
| rd_push | input | 1 | Application writes one read data word |
| rd_wdata | input | 32 | Read data word |
| rd_full | output | 1 | Read data FIFO holds FIFO_DEPTH words |

## Verification
The hardest case to reach is the one where a repeat is almost right. Either it matches exactly while the FIFO is still empty, or it differs only in the byte enables or the command while data is already waiting. Both must be retried without a pop. The stimulus gets there by issuing each kind of repeat first while no word has been pushed. It then pushes words and repeats the near-misses before the exact repeat. Finally it fills the FIFO past its depth, so that the order of data across several back-to-back delayed requests, and the discarded overflow word, show up on the bus.

// File: rtl/dlyrd_pkg.sv
package dlyrd_pkg;
  localparam int BUS_W = 32;
  localparam int CBE_W = 4;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECODE,
    ST_HOLD
  } tgt_state_t;

  function automatic logic is_read(input logic [3:0] cmd);
    return (cmd == CMD_IO_RD) || (cmd == CMD_MEM_RD);
  endfunction

  function automatic logic is_claimable(input logic [3:0] cmd);
    return (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR) ||
           (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
  endfunction
endpackage

// File: rtl/dlyrd_decode.sv
module dlyrd_decode
  import dlyrd_pkg::*;
#(
  parameter logic [BUS_W-1:0] WIN_BASE  = 32'h0000_1000,
  parameter int               WIN_BYTES = 256
) (
  input  logic [CBE_W-1:0] cmd,
  input  logic [BUS_W-1:0] addr,
  output logic             hit
);
  localparam logic [BUS_W-1:0] HI_MASK = ~(BUS_W'(WIN_BYTES) - 1'b1);

  always_comb begin
    hit = (((addr ^ WIN_BASE) & HI_MASK) == '0) && is_claimable(cmd);
  end
endmodule

// File: rtl/dlyrd_reqlat.sv
module dlyrd_reqlat
  import dlyrd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic             clr,
  input  logic [CBE_W-1:0] cmd,
  input  logic [BUS_W-1:0] addr,
  input  logic [CBE_W-1:0] be,
  output logic             pend,
  output logic             match,
  output logic [CBE_W-1:0] lat_cmd,
  output logic [BUS_W-1:0] lat_addr,
  output logic [CBE_W-1:0] lat_be
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      lat_cmd  <= '0;
      lat_addr <= '0;
      lat_be   <= '0;
    end else if (clr) begin
      pend <= 1'b0;
    end else if (cap_en) begin
      pend     <= 1'b1;
      lat_cmd  <= cmd;
      lat_addr <= addr;
      lat_be   <= be;
    end
  end

  always_comb begin
    match = (cmd == lat_cmd) && (addr == lat_addr) && (be == lat_be);
  end
endmodule

// File: rtl/dlyrd_rdfifo.sv
module dlyrd_rdfifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int          AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          push_ok, pop_ok;

  always_comb begin
    empty   = (count == '0);
    full    = (count == (AW+1)'(DEPTH));
    push_ok = push && !full;
    pop_ok  = pop && !empty;
    head    = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/pci_dlyrd_tgt.sv
module pci_dlyrd_tgt
  import dlyrd_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'h0000_1000,
  parameter int          WIN_BYTES  = 256,
  parameter int          FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bypass_dly,
  input  logic        bus_frame_l,
  input  logic        bus_irdy_l,
  input  logic [31:0] bus_ad,
  input  logic [3:0]  bus_cbe_l,
  output logic        tgt_devsel_l,
  output logic        tgt_trdy_l,
  output logic        tgt_stop_l,
  output logic [31:0] tgt_ad,
  output logic        tgt_ad_oe,
  output logic        req_push,
  output logic [3:0]  req_cmd,
  output logic [31:0] req_addr,
  output logic [3:0]  req_be,
  input  logic        rd_push,
  input  logic [31:0] rd_wdata,
  output logic        rd_full
);
  tgt_state_t        state;
  logic              frame_q;
  logic [CBE_W-1:0]  a_cmd;
  logic [BUS_W-1:0]  a_addr;
  logic              give_q;
  logic              hit, pend, match, empty;
  logic [BUS_W-1:0]  head;
  logic              addr_clk, give, cap, pop;

  dlyrd_decode #(.WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_dec (
    .cmd (bus_cbe_l),
    .addr(bus_ad),
    .hit (hit)
  );

  dlyrd_reqlat u_lat (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap),
    .clr     (pop),
    .cmd     (a_cmd),
    .addr    (a_addr),
    .be      (bus_cbe_l),
    .pend    (pend),
    .match   (match),
    .lat_cmd (req_cmd),
    .lat_addr(req_addr),
    .lat_be  (req_be)
  );

  dlyrd_rdfifo #(.DW(BUS_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .push (rd_push),
    .wdata(rd_wdata),
    .pop  (pop),
    .head (head),
    .empty(empty),
    .full (rd_full)
  );

  always_comb begin
    addr_clk = (state == ST_IDLE) && !bus_frame_l && frame_q;
    give     = (state == ST_DECODE) && pend && match && !empty;
    cap      = (state == ST_DECODE) && !pend && is_read(a_cmd);
    pop      = (state == ST_HOLD) && bus_frame_l && !bus_irdy_l && give_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      frame_q      <= 1'b1;
      a_cmd        <= '0;
      a_addr       <= '0;
      give_q       <= 1'b0;
      tgt_devsel_l <= 1'b1;
      tgt_trdy_l   <= 1'b1;
      tgt_stop_l   <= 1'b1;
      tgt_ad       <= '0;
      tgt_ad_oe    <= 1'b0;
      req_push     <= 1'b0;
    end else begin
      frame_q  <= bus_frame_l;
      req_push <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (addr_clk && hit && !bypass_dly) begin
            state  <= ST_DECODE;
            a_cmd  <= bus_cbe_l;
            a_addr <= bus_ad;
          end
        end
        ST_DECODE: begin
          state        <= ST_HOLD;
          tgt_devsel_l <= 1'b0;
          tgt_stop_l   <= 1'b0;
          if (give) begin
            tgt_trdy_l <= 1'b0;
            tgt_ad_oe  <= 1'b1;
            tgt_ad     <= head;
            give_q     <= 1'b1;
          end else if (cap) begin
            req_push <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (bus_frame_l && !bus_irdy_l) begin
            state        <= ST_IDLE;
            tgt_devsel_l <= 1'b1;
            tgt_trdy_l   <= 1'b1;
            tgt_stop_l   <= 1'b1;
            tgt_ad_oe    <= 1'b0;
            give_q       <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dlyrd_chk.sv
module dlyrd_chk (
  input logic clk,
  input logic rst,
  input logic bus_frame_l,
  input logic bus_irdy_l,
  input logic tgt_devsel_l,
  input logic tgt_trdy_l,
  input logic tgt_stop_l,
  input logic tgt_ad_oe,
  input logic req_push
);
  // R2
  stop_with_devsel_chk: assert property (@(posedge clk) disable iff (rst)
    !tgt_stop_l |-> !tgt_devsel_l);

  // R5
  trdy_needs_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !tgt_trdy_l |-> (!tgt_stop_l && tgt_ad_oe));

  // R3
  push_is_retry_chk: assert property (@(posedge clk) disable iff (rst)
    req_push |-> (tgt_trdy_l && !tgt_stop_l && !tgt_devsel_l));

  // R3
  push_single_chk: assert property (@(posedge clk) disable iff (rst)
    req_push |=> !req_push);

  // R2
  devsel_timing_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tgt_devsel_l) |-> (!$past(bus_frame_l, 2) && $past(bus_frame_l, 3)));

  // R2
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (!tgt_devsel_l && bus_frame_l && !bus_irdy_l) |=>
      (tgt_devsel_l && tgt_stop_l && tgt_trdy_l && !tgt_ad_oe));
endmodule

bind pci_dlyrd_tgt dlyrd_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_frame_l (bus_frame_l),
  .bus_irdy_l  (bus_irdy_l),
  .tgt_devsel_l(tgt_devsel_l),
  .tgt_trdy_l  (tgt_trdy_l),
  .tgt_stop_l  (tgt_stop_l),
  .tgt_ad_oe   (tgt_ad_oe),
  .req_push    (req_push)
);

// File: tb/tb_pci_dlyrd_tgt.sv
`timescale 1ns/1ps
module tb_pci_dlyrd_tgt;
  localparam logic [31:0] BASE  = 32'h0000_1000;
  localparam int          BYTES = 256;
  localparam int          DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bypass_dly = 1'b0;
  logic        bus_frame_l = 1'b1;
  logic        bus_irdy_l = 1'b1;
  logic [31:0] bus_ad = '0;
  logic [3:0]  bus_cbe_l = '0;
  logic        rd_push = 1'b0;
  logic [31:0] rd_wdata = '0;
  logic        tgt_devsel_l, tgt_trdy_l, tgt_stop_l, tgt_ad_oe, req_push, rd_full;
  logic [31:0] tgt_ad, req_addr;
  logic [3:0]  req_cmd, req_be;

  pci_dlyrd_tgt #(.WIN_BASE(BASE), .WIN_BYTES(BYTES), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .bypass_dly(bypass_dly),
    .bus_frame_l(bus_frame_l), .bus_irdy_l(bus_irdy_l),
    .bus_ad(bus_ad), .bus_cbe_l(bus_cbe_l),
    .tgt_devsel_l(tgt_devsel_l), .tgt_trdy_l(tgt_trdy_l), .tgt_stop_l(tgt_stop_l),
    .tgt_ad(tgt_ad), .tgt_ad_oe(tgt_ad_oe),
    .req_push(req_push), .req_cmd(req_cmd), .req_addr(req_addr), .req_be(req_be),
    .rd_push(rd_push), .rd_wdata(rd_wdata), .rd_full(rd_full)
  );

  always #10 clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  int    push_seen = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // behavioural reference model
  int          m_st = 0;
  bit          m_fq = 1'b1, m_pend = 1'b0, m_give = 1'b0;
  logic [3:0]  m_acmd, m_lcmd, m_lbe;
  logic [31:0] m_aaddr, m_laddr;
  logic [31:0] q[$];
  bit          e_dev = 1, e_trdy = 1, e_stop = 1, e_oe = 0, e_push = 0, e_full = 0;
  logic [31:0] e_ad;

  function automatic bit in_win(input logic [3:0] c, input logic [31:0] a);
    return (a >= BASE) && (a < BASE + BYTES) &&
           (c == 4'b0010 || c == 4'b0011 || c == 4'b0110 || c == 4'b0111);
  endfunction

  always @(posedge clk) begin
    int sz0;
    sz0 = q.size();
    e_push = 0;
    if (rst) begin
      m_st = 0; m_fq = 1; m_pend = 0; m_give = 0; q.delete(); sz0 = 0;
      e_dev = 1; e_trdy = 1; e_stop = 1; e_oe = 0;
    end else begin
      if (m_st == 0) begin
        if (!bus_frame_l && m_fq && !bypass_dly && in_win(bus_cbe_l, bus_ad)) begin
          m_st = 1; m_acmd = bus_cbe_l; m_aaddr = bus_ad;
        end
      end else if (m_st == 1) begin
        m_st = 2; e_dev = 0; e_stop = 0;
        if (m_pend && sz0 > 0 && m_acmd == m_lcmd && m_aaddr == m_laddr && bus_cbe_l == m_lbe) begin
          e_trdy = 0; e_oe = 1; e_ad = q[0]; m_give = 1;
        end else if (!m_pend && (m_acmd == 4'b0010 || m_acmd == 4'b0110)) begin
          m_pend = 1; m_lcmd = m_acmd; m_laddr = m_aaddr; m_lbe = bus_cbe_l; e_push = 1;
        end
      end else begin
        if (bus_frame_l && !bus_irdy_l) begin
          e_dev = 1; e_trdy = 1; e_stop = 1; e_oe = 0; m_st = 0;
          if (m_give) begin void'(q.pop_front()); m_pend = 0; m_give = 0; end
        end
      end
      if (rd_push && sz0 < DEPTH) q.push_back(rd_wdata);
      m_fq = bus_frame_l;
    end
    e_full = (q.size() == DEPTH);
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tgt_devsel_l == e_dev, "devsel", 32'(tgt_devsel_l), 32'(e_dev));
      chk(tgt_stop_l == e_stop, "stop", 32'(tgt_stop_l), 32'(e_stop));
      chk(tgt_trdy_l == e_trdy, "trdy", 32'(tgt_trdy_l), 32'(e_trdy));
      chk(tgt_ad_oe == e_oe, "ad_oe", 32'(tgt_ad_oe), 32'(e_oe));
      chk(req_push == e_push, "req_push", 32'(req_push), 32'(e_push));
      chk(rd_full == e_full, "rd_full", 32'(rd_full), 32'(e_full));
      if (e_oe) chk(tgt_ad == e_ad, "tgt_ad", tgt_ad, e_ad);
      if (e_push) begin
        chk(req_cmd == m_lcmd, "req_cmd", 32'(req_cmd), 32'(m_lcmd));
        chk(req_addr == m_laddr, "req_addr", req_addr, m_laddr);
        chk(req_be == m_lbe, "req_be", 32'(req_be), 32'(m_lbe));
      end
      if (req_push) push_seen++;
    end
  end

  task automatic txn(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b);
    @(posedge clk); #2 bus_frame_l = 0; bus_ad = a; bus_cbe_l = c; bus_irdy_l = 1;
    @(posedge clk); #2 bus_cbe_l = b; bus_ad = 32'hDEAD_0000; bus_irdy_l = 0;
    @(posedge clk); @(posedge clk); @(posedge clk); #2 bus_frame_l = 1;
    @(posedge clk); #2 bus_irdy_l = 1; bus_cbe_l = 0; bus_ad = 0;
    @(posedge clk);
  endtask

  task automatic pushd(input logic [31:0] d);
    @(posedge clk); #2 rd_push = 1; rd_wdata = d;
    @(posedge clk); #2 rd_push = 0;
  endtask

  task automatic count_chk(input int exp);
    chk(push_seen == exp, "push count", 32'(push_seen), 32'(exp));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    tag = "R1";
    chk(tgt_devsel_l && tgt_trdy_l && tgt_stop_l, "idle outputs", 32'({tgt_devsel_l, tgt_trdy_l, tgt_stop_l}), 32'h7);
    chk(!tgt_ad_oe && !req_push && !rd_full, "idle flags", 32'({tgt_ad_oe, req_push, rd_full}), 32'h0);

    tag = "R8"; bypass_dly = 1;
    txn(4'b0010, BASE + 32'h10, 4'b0000);
    bypass_dly = 0; count_chk(0);

    tag = "R7";
    txn(4'b0010, BASE + BYTES, 4'b0000);
    txn(4'b0010, BASE - 4, 4'b0000);
    txn(4'b1010, BASE + 32'h10, 4'b0000);
    count_chk(0);

    tag = "R10";
    txn(4'b0011, BASE + 32'h10, 4'b0000);
    txn(4'b0111, BASE + 32'h14, 4'b0000);
    count_chk(0);

    tag = "R3";
    txn(4'b0010, BASE + 32'h20, 4'b1100);
    count_chk(1);

    tag = "R4";
    txn(4'b0010, BASE + 32'h20, 4'b1100);
    txn(4'b0010, BASE + 32'h20, 4'b1110);
    txn(4'b0011, BASE + 32'h20, 4'b1100);
    txn(4'b0110, BASE + 32'h20, 4'b1100);
    txn(4'b0010, BASE + 32'h24, 4'b1100);
    pushd(32'hA5A5_0001);
    txn(4'b0010, BASE + 32'h20, 4'b0100);
    txn(4'b0111, BASE + 32'h40, 4'b0000);
    count_chk(1);

    tag = "R5";
    txn(4'b0010, BASE + 32'h20, 4'b1100);

    tag = "R6";
    txn(4'b0110, BASE + 32'h80, 4'b0000);
    count_chk(2);
    tag = "R2";
    pushd(32'h1234_5678);
    txn(4'b0110, BASE + 32'h80, 4'b0000);

    tag = "R9";
    for (int i = 0; i < DEPTH + 1; i++) pushd(32'hC0DE_0000 + 32'(i));
    @(negedge clk);
    chk(rd_full == 1'b1, "full flag", 32'(rd_full), 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      txn(4'b0010, BASE + 32'(i * 4), 4'(i));
      txn(4'b0010, BASE + 32'(i * 4), 4'(i));
    end
    @(negedge clk);
    chk(rd_full == 1'b0, "drained", 32'(rd_full), 32'h0);
    count_chk(2 + DEPTH);

    repeat (4) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule